// File: doc/BRIEF.md
# Virtual-Function BAR Address Decoder

This block resolves a memory address against the virtual-function BAR of a physical function that supports single-root I/O virtualisation. A single programmed base address opens one contiguous window. The window is divided into equal slices, one per enabled virtual function, in index order. For an address inside the window, the decoder reports a hit, the index of the function that owns the slice, and the byte offset within that function's BAR. Addresses outside the window, or any address while the function array is disabled or misconfigured, produce no hit.

The per-function BAR size is a power of two and is given as its log2. The base needs to be aligned only to one slice, not to the whole window. A base that breaks this rule, or a size outside the supported range, is reported as a configuration error, and decoding stays off while the error persists. The block also serves configuration reads aimed at the BAR registers inside each virtual function's own header. Those registers always read as zero, and the block marks such reads as claimed.

All outputs are registered and are valid one clock after the inputs they reflect.

Top module: `vf_bar_decoder`

## Requirements
- R1: While reset is asserted, `hit`, `vfIndex`, `offset`, `cfgErr`, `cfgBarSel` and `cfgRdData` are all zero.
- R2: An address A with base B ≤ A < B + numVfs × 2^sizeLog2 hits one cycle later. In that case `vfIndex` = (A − B) >> sizeLog2 and `offset` = (A − B) mod 2^sizeLog2.
- R3: An address at or above B + numVfs × 2^sizeLog2, or below B, does not hit. When `numVfs` is zero, no address hits.
- R4: When `vfEnable` is low, no address hits.
- R5: `cfgErr` rises one cycle after the base has any of its low sizeLog2 bits set, or after `sizeLog2` lies outside MIN_SIZE_LOG2..MAX_SIZE_LOG2. While `cfgErr` is set, no address hits.
- R6: Only the alignment to one slice is required. A base aligned to 2^sizeLog2 but not to the window size decodes normally. For example, eight functions with a 1 MB BAR (sizeLog2 = 20) at base 0x0030_0000 cover 0x0030_0000 up to 0x00AF_FFFF.
- R7: With `addrValid` low, `hit` is low the next cycle. While `hit` is low, `vfIndex` and `offset` read zero.
- R8: A config read (`cfgRdEn` high) at byte offset 0x10, 0x14, 0x18, 0x1C, 0x20 or 0x24 sets `cfgBarSel` one cycle later. At every other offset, `cfgBarSel` stays low. `cfgRdData` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrValid | input | 1 | Address on `addr` is to be decoded |
| addr | input | ADDR_W | Incoming memory address |
| barBase | input | ADDR_W | Programmed base of the virtual-function window |
| sizeLog2 | input | SZ_W | log2 of one function's BAR size |
| numVfs | input | VF_W | Number of enabled virtual functions |
| vfEnable | input | 1 | Virtual functions enabled |
| cfgRdEn | input | 1 | Config read to a virtual function header |
| cfgAddr | input | 8 | Byte offset of the config read |
| hit | output | 1 | Address lies in an enabled function's slice |
| vfIndex | output | VF_W | Index of the function hit |
| offset | output | ADDR_W | Byte offset within that function's BAR |
| cfgErr | output | 1 | Base misaligned or size out of range |
| cfgBarSel | output | 1 | Config read targeted a header BAR register |
| cfgRdData | output | 32 | Read data for the header BAR registers |

## Verification
Some assertions compare the registered outputs with the inputs of the cycle before. These assertions assume that `numVfs`, `sizeLog2` and `vfEnable` are known values whenever `addrValid` is high. The bench always drives defined values and changes inputs only half a cycle away from the sampling edge. Random bases are forced onto slice alignment, apart from deliberate misalignment cases, and sizes stay inside the legal range, apart from deliberate range violations. Random addresses cluster around the window: just below the base, inside it, and a few slices past its end. This makes both edges of the window frequent.

// File: rtl/vf_dec_pkg.sv
package vf_dec_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic capture;   // an address is presented this cycle
    logic allowHit;  // configuration permits a hit
  } vfDecStrobe_t;

  // Header BAR registers occupy dword offsets 4..9 (bytes 0x10..0x24).
  function automatic logic isHdrBar(input logic [7:0] byteOff);
    return (byteOff[1:0] == 2'b00) && (byteOff[7:2] >= 6'd4) && (byteOff[7:2] <= 6'd9);
  endfunction

endpackage

// File: rtl/vf_dec_ctrl.sv
module vf_dec_ctrl
  import vf_dec_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SZ_W          = 5,
  parameter int MIN_SIZE_LOG2 = 12,
  parameter int MAX_SIZE_LOG2 = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              vfEnable,
  input  logic [ADDR_W-1:0] barBase,
  input  logic [SZ_W-1:0]   sizeLog2,
  output vfDecStrobe_t      strobe,
  output logic              cfgErr
);

  localparam logic [SZ_W-1:0] MIN_SZ = SZ_W'(MIN_SIZE_LOG2);
  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(MAX_SIZE_LOG2);

  logic [ADDR_W-1:0] sliceMask;
  logic              sizeBad;
  logic              misaligned;
  logic              errNow;

  always_comb begin
    sliceMask  = (ADDR_W'(1) << sizeLog2) - ADDR_W'(1);
    sizeBad    = (sizeLog2 < MIN_SZ) || (sizeLog2 > MAX_SZ);
    misaligned = (barBase & sliceMask) != '0;
    errNow     = sizeBad || misaligned;
    strobe.capture  = addrValid;
    strobe.allowHit = vfEnable && !errNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= errNow;
  end

endmodule

// File: rtl/vf_dec_dpath.sv
module vf_dec_dpath
  import vf_dec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 5,
  parameter int VF_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfDecStrobe_t      strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] barBase,
  input  logic [SZ_W-1:0]   sizeLog2,
  input  logic [VF_W-1:0]   numVfs,
  input  logic              cfgRdEn,
  input  logic [7:0]        cfgAddr,
  output logic              hit,
  output logic [VF_W-1:0]   vfIndex,
  output logic [ADDR_W-1:0] offset,
  output logic              cfgBarSel,
  output logic [31:0]       cfgRdData
);

  localparam int PAD_W = ADDR_W - VF_W;

  logic [ADDR_W-1:0] distance;
  logic [ADDR_W-1:0] sliceIdx;
  logic [ADDR_W-1:0] sliceOff;
  logic [ADDR_W-1:0] sliceMask;
  logic              aboveBase;
  logic              belowEnd;
  logic              hitNow;

  always_comb begin
    distance  = addr - barBase;
    aboveBase = addr >= barBase;
    sliceMask = (ADDR_W'(1) << sizeLog2) - ADDR_W'(1);
    sliceIdx  = distance >> sizeLog2;
    sliceOff  = distance & sliceMask;
    belowEnd  = sliceIdx < {{PAD_W{1'b0}}, numVfs};
    hitNow    = strobe.capture && strobe.allowHit && aboveBase && belowEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit     <= 1'b0;
      vfIndex <= '0;
      offset  <= '0;
    end else begin
      hit     <= hitNow;
      vfIndex <= hitNow ? sliceIdx[VF_W-1:0] : '0;
      offset  <= hitNow ? sliceOff : '0;
    end
  end

  // Header BARs of a virtual function are hard-wired to zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBarSel <= 1'b0;
      cfgRdData <= '0;
    end else begin
      cfgBarSel <= cfgRdEn && isHdrBar(cfgAddr);
      cfgRdData <= '0;
    end
  end

endmodule

// File: rtl/vf_bar_decoder.sv
module vf_bar_decoder
  import vf_dec_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int VF_W          = 8,
  parameter int MIN_SIZE_LOG2 = 12,
  parameter int MAX_SIZE_LOG2 = 28,
  parameter int SZ_W          = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] barBase,
  input  logic [SZ_W-1:0]   sizeLog2,
  input  logic [VF_W-1:0]   numVfs,
  input  logic              vfEnable,
  input  logic              cfgRdEn,
  input  logic [7:0]        cfgAddr,
  output logic              hit,
  output logic [VF_W-1:0]   vfIndex,
  output logic [ADDR_W-1:0] offset,
  output logic              cfgErr,
  output logic              cfgBarSel,
  output logic [31:0]       cfgRdData
);

  vfDecStrobe_t strobe;

  vf_dec_ctrl #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W),
    .MIN_SIZE_LOG2(MIN_SIZE_LOG2), .MAX_SIZE_LOG2(MAX_SIZE_LOG2)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .vfEnable(vfEnable),
    .barBase(barBase), .sizeLog2(sizeLog2), .strobe(strobe), .cfgErr(cfgErr)
  );

  vf_dec_dpath #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .VF_W(VF_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .barBase(barBase),
    .sizeLog2(sizeLog2), .numVfs(numVfs), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .hit(hit), .vfIndex(vfIndex), .offset(offset),
    .cfgBarSel(cfgBarSel), .cfgRdData(cfgRdData)
  );

endmodule

// File: rtl/vf_bar_decoder_chk.sv
module vf_bar_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int VF_W   = 8,
  parameter int SZ_W   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrValid,
  input logic [SZ_W-1:0]   sizeLog2,
  input logic [VF_W-1:0]   numVfs,
  input logic              vfEnable,
  input logic              hit,
  input logic [VF_W-1:0]   vfIndex,
  input logic [ADDR_W-1:0] offset,
  input logic              cfgErr
);

  AST_INDEX_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> vfIndex < $past(numVfs)); // R3
  AST_OFFSET_IN_SLICE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (offset >> $past(sizeLog2)) == '0); // R2
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(vfEnable) |-> !hit); // R4
  AST_ERR_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !hit); // R5
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(addrValid) |-> !hit); // R7
  AST_MISS_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (vfIndex == '0 && offset == '0)); // R7

endmodule

bind vf_bar_decoder vf_bar_decoder_chk #(
  .ADDR_W(ADDR_W), .VF_W(VF_W), .SZ_W(SZ_W)
) i_chk (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .sizeLog2(sizeLog2),
  .numVfs(numVfs), .vfEnable(vfEnable), .hit(hit), .vfIndex(vfIndex),
  .offset(offset), .cfgErr(cfgErr)
);

// File: tb/test_vf_bar_decoder.sv
module test_vf_bar_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] barBase = '0;
  logic [4:0]  sizeLog2 = 5'd20;
  logic [7:0]  numVfs = '0;
  logic        vfEnable = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic        hit;
  logic [7:0]  vfIndex;
  logic [31:0] offset;
  logic        cfgErr;
  logic        cfgBarSel;
  logic [31:0] cfgRdData;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  vf_bar_decoder i_vf_bar_decoder (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addr(addr),
    .barBase(barBase), .sizeLog2(sizeLog2), .numVfs(numVfs),
    .vfEnable(vfEnable), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .hit(hit), .vfIndex(vfIndex), .offset(offset), .cfgErr(cfgErr),
    .cfgBarSel(cfgBarSel), .cfgRdData(cfgRdData)
  );

  function automatic logic expErr(input logic [31:0] b, input logic [4:0] s);
    logic [31:0] m;
    m = (32'd1 << s) - 32'd1;
    return (s < 5'd12) || (s > 5'd28) || ((b & m) != 0);
  endfunction

  function automatic logic [71:0] expDecode(input logic [31:0] a, input logic [31:0] b,
      input logic [4:0] s, input logic [7:0] n, input logic en, input logic v);
    longint unsigned d, lim;
    logic h;
    logic [7:0] ix;
    logic [31:0] of;
    lim = longint'(n) << s;
    d   = longint'(a) - longint'(b);
    h   = v && en && !expErr(b, s) && (a >= b) && (d < lim);
    ix  = h ? 8'(d >> s) : 8'd0;
    of  = h ? 32'(d % (longint'(1) << s)) : 32'd0;
    return {ix, of, 31'd0, h};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic decode(input string req, input logic [31:0] a, input logic v = 1'b1);
    logic [71:0] e;
    @(negedge clk);
    addr = a; addrValid = v;
    e = expDecode(a, barBase, sizeLog2, numVfs, vfEnable, v);
    @(negedge clk);
    check({req, " hit"}, {63'd0, hit}, {63'd0, e[0]});
    check({req, " index/offset"}, {24'd0, vfIndex, offset}, {24'd0, e[71:64], e[63:32]});
    check({req, " cfgErr"}, {63'd0, cfgErr}, {63'd0, expErr(barBase, sizeLog2)});
    addrValid = 1'b0;
  endtask

  task automatic setCfg(input logic [31:0] b, input logic [4:0] s, input logic [7:0] n, input logic en);
    @(negedge clk);
    barBase = b; sizeLog2 = s; numVfs = n; vfEnable = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    addr = 32'hFFFF_FFFF; addrValid = 1'b1; vfEnable = 1'b1; numVfs = 8'd8;
    cfgRdEn = 1'b1; cfgAddr = 8'h10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset", {hit, vfIndex, cfgErr, cfgBarSel}, '0);
    check("R1 reset data", {offset, cfgRdData}, '0);
    addrValid = 1'b0; cfgRdEn = 1'b0;
    rstN = 1'b1;

    // R6: 8 functions x 1 MB at a base aligned to 1 MB only
    setCfg(32'h0030_0000, 5'd20, 8'd8, 1'b1);
    decode("R6 first byte", 32'h0030_0000);
    decode("R6 last byte", 32'h00AF_FFFF);
    decode("R6 mid slice5", 32'h0085_1234);
    decode("R3 one past end", 32'h00B0_0000);
    decode("R3 below base", 32'h002F_FFFF);
    decode("R7 invalid addr", 32'h0040_0000, 1'b0);

    // R4: disabled
    setCfg(32'h0030_0000, 5'd20, 8'd8, 1'b0);
    decode("R4 disabled", 32'h0040_0000);

    // R3: zero functions
    setCfg(32'h0030_0000, 5'd20, 8'd0, 1'b1);
    decode("R3 zero vfs", 32'h0030_0000);

    // R5: misaligned base and bad sizes
    setCfg(32'h0030_8000, 5'd20, 8'd8, 1'b1);
    decode("R5 misaligned", 32'h0040_0000);
    setCfg(32'h0030_0000, 5'd11, 8'd8, 1'b1);
    decode("R5 size small", 32'h0030_0000);
    setCfg(32'h0000_0000, 5'd29, 8'd2, 1'b1);
    decode("R5 size large", 32'h0000_0010);
    setCfg(32'h1000_0000, 5'd28, 8'd1, 1'b1);
    decode("R5 max size ok", 32'h1FFF_FFFF);

    // R2: window past top of address space
    setCfg(32'hFFF0_0000, 5'd16, 8'd255, 1'b1);
    decode("R2 top wrap last", 32'hFFFF_FFFF);
    decode("R3 top wrap low", 32'h0000_0004);

    // R8: header BAR reads
    for (int k = 0; k < 64; k++) begin
      logic [7:0] off;
      off = 8'(k * 4) + ((k % 7 == 3) ? 8'd2 : 8'd0);
      @(negedge clk);
      cfgRdEn = (k % 5 != 4); cfgAddr = off;
      @(negedge clk);
      check("R8 barSel", {63'd0, cfgBarSel},
            {63'd0, cfgRdEn && off[1:0] == 0 && off >= 8'h10 && off <= 8'h24});
      check("R8 data zero", {32'd0, cfgRdData}, 64'd0);
    end
    cfgRdEn = 1'b0;

    // R2/R3/R5/R6: random configurations
    for (int t = 0; t < 400; t++) begin
      logic [4:0]  s;
      logic [31:0] b, a;
      logic [7:0]  n;
      s = 5'(12 + $urandom_range(0, 16));
      if ($urandom_range(0, 9) == 0) s = 5'($urandom_range(0, 31));
      n = 8'($urandom_range(0, 20));
      if ($urandom_range(0, 7) == 0) n = 8'($urandom_range(0, 255));
      b = $urandom() & ~((32'd1 << s) - 32'd1);
      if ($urandom_range(0, 9) == 0) b = $urandom();
      setCfg(b, s, n, $urandom_range(0, 15) != 0);
      for (int j = 0; j < 4; j++) begin
        a = b + ((32'($urandom_range(0, 32'(n) + 2))) << s) + ($urandom() & ((32'd1 << s) - 32'd1));
        if ($urandom_range(0, 5) == 0) a = b - 32'($urandom_range(1, 64));
        decode("R2 random", a, $urandom_range(0, 9) != 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule